// File: doc/BRIEF.md
# Processor Debug-Entry Controller

This block decides when a pipelined processor core stops and goes into debug state. Four sources can ask for a halt. The first is an external request pin. The second is a halt bit in a small control register. The third is an instruction breakpoint flag that is attached to an instruction when it leaves fetch and travels with it down the pipeline. The fourth is a data watchpoint flag that is sampled one cycle after a data access request. A global enable input gates every entry source. When it is low, breakpoint tags carried in the pipeline are also disregarded.

The core's pipeline is represented by a token model with a parameterised depth (fetch, decode, execute by default). Each stage holds a valid bit and a breakpoint tag. A branch flush empties every stage younger than execute. On entry the instruction in execute leaves the pipeline. It has either completed (request-driven entry) or been suppressed (breakpoint entry). The younger stages freeze until a restart input releases debug state.

The block drives four outputs: the merged request as presented to the core, a debug-acknowledge level, a one-cycle executed pulse, and a sticky record of which sources caused the current halt.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: `dbg_req_core` is combinationally `ext_req` OR control-register bit 1, independent of `dbg_en`. The register is loaded from `ctrl_wdata` on a clock edge where `ctrl_we` is high. No other register bit has any effect.
- R2: With `dbg_en` high and no halt in progress, a merged request (external or control bit) present in a cycle sets `dbg_ack` at that cycle's closing edge. The instruction in execute during that cycle still completes, so `instr_exec` also rises at that edge when it passes its condition.
- R3: `ibkpt` is sampled in the cycle in which an instruction moves from fetch to decode, which is the cycle after its `fetch_req` when nothing stalls. It tags that instruction. A tagged instruction that reaches execute with `dbg_en` high sets `dbg_ack` at the closing edge of its execute cycle, three edges after its fetch edge. That instruction does not produce an `instr_exec` pulse.
- R4: `flush` empties the fetch and decode stages and stops the decode instruction from entering execute. A fetch request in the same cycle is dropped. A flushed instruction never executes and never halts the core, even if tagged. The instruction already in execute is unaffected.
- R5: If `dwpt` is high with `dbg_en` high in the cycle right after a cycle with `dmem_req` high (taken outside debug state), `dbg_ack` rises at that cycle's closing edge. `dwpt` without a preceding `dmem_req` is ignored.
- R6: In debug state, `dbg_ack` stays high until a restart. The pipeline is frozen, `instr_exec` stays low, `fetch_req`, `dmem_req` and `flush` are ignored, and the cause record does not change. After restart a frozen fetch-stage instruction executes three edges after the restart edge.
- R7: While `dbg_en` is low, no source ever sets `dbg_ack`. A breakpoint-tagged instruction then executes normally.
- R8: `instr_exec` is high for exactly the one cycle after a valid, non-suppressed execute-stage instruction saw `cond_pass` high. It stays low if `cond_pass` was low.
- R9: `restart` high in debug state clears `dbg_ack` and `dbg_cause` at that edge. If control bit 1 is still set, the block re-enters debug state at the next edge.
- R10: Sources firing together give a single entry. `dbg_cause` records them with bit 0 = external input, bit 1 = control bit, bit 2 = breakpoint, bit 3 = watchpoint. `dbg_cause` is nonzero exactly while `dbg_ack` is high.
- R11: After the active-low synchronous reset, `dbg_ack`, `instr_exec`, `dbg_cause` and the control register are zero and the pipeline is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dbg_en | input | 1 | Global enable for all debug entry sources |
| ext_req | input | 1 | External halt request |
| ctrl_we | input | 1 | Load strobe for the control register |
| ctrl_wdata | input | CTRL_W | Control register write value (bit 1 = halt request) |
| fetch_req | input | 1 | Instruction fetch request, creates a fetch-stage token |
| ibkpt | input | 1 | Instruction breakpoint flag for the instruction leaving fetch |
| flush | input | 1 | Branch flush of fetch and decode |
| cond_pass | input | 1 | Execute-stage instruction passes its condition |
| dmem_req | input | 1 | Data memory request |
| dwpt | input | 1 | Data watchpoint flag, sampled the cycle after a data request |
| restart | input | 1 | Leave debug state |
| dbg_req_core | output | 1 | Merged request presented to the core |
| dbg_ack | output | 1 | High while in debug state |
| instr_exec | output | 1 | Pulse: previous execute-stage instruction executed |
| dbg_cause | output | 4 | Sticky record of sources behind the current halt |

## Verification
The checker assumes that inputs are clean synchronous levels, and that reset is held low across at least one rising edge before any history-based property is trusted. A local flag marks the first cycle after reset, and properties that look one cycle back are gated by it. The bench changes inputs only just after each rising edge, and it asserts `restart` only after a halt or after a deliberate idle cycle. It keeps `ibkpt` and `cond_pass` aligned with the cycle the token model defines for them, so that the arithmetic expectations for each swept combination of enable, tag, condition and flush position are unambiguous.

// File: rtl/dbg_entry_pkg.sv
// Shared types for the debug-entry controller.
// Assumes: cause bit order is part of the visible behaviour.
package dbg_entry_pkg;
    localparam int CAUSE_W    = 4;
    localparam int CAUSE_EXT  = 0;
    localparam int CAUSE_CTRL = 1;
    localparam int CAUSE_BKPT = 2;
    localparam int CAUSE_WPT  = 3;

    // One pipeline slot: occupancy and breakpoint tag of its instruction.
    typedef struct packed {
        logic vld;
        logic bkpt;
    } slot_t;

    typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/dbg_pipe_model.sv
// Token model of the core pipeline: stage 0 is fetch, the last stage is
// execute. The breakpoint flag is attached when a token leaves fetch.
// Assumes: DEPTH >= 3; hold freezes everything; drain_ex removes the
// execute token and freezes the younger stages for that edge.
module dbg_pipe_model
    import dbg_entry_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hold,
    input  logic  drain_ex,
    input  logic  fetch_req,
    input  logic  flush,
    input  logic  ibkpt,
    output slot_t ex_slot
);
    localparam int EX = DEPTH - 1;

    slot_t [DEPTH-1:0] stg;
    slot_t [DEPTH-1:0] nxt;
    logic              adv;

    assign adv = !drain_ex;

    // Fetch stage: new token on request, cleared by flush.
    assign nxt[0] = flush ? '0 :
                    (adv ? slot_t'{vld: fetch_req, bkpt: 1'b0} : stg[0]);

    // First decode stage: attach the breakpoint flag on the way in.
    assign nxt[1] = flush ? '0 :
                    (adv ? slot_t'{vld: stg[0].vld,
                                   bkpt: stg[0].bkpt | (stg[0].vld & ibkpt)}
                         : stg[1]);

    // Further decode stages for deeper configurations.
    generate
        for (genvar k = 2; k < EX; k++) begin : g_mid
            assign nxt[k] = flush ? '0 : (adv ? stg[k-1] : stg[k]);
        end
    endgenerate

    // Execute stage: a flushed or draining pipeline feeds it nothing.
    assign nxt[EX] = (flush || drain_ex) ? '0 : stg[EX-1];

    // Stage registers: advance unless the core is halted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else if (!hold) begin
            stg <= nxt;
        end
    end

    assign ex_slot = stg[EX];
endmodule

// File: rtl/dbg_src_merge.sv
// Collects the debug entry sources: control register, merged request,
// delayed data-request flag and the execute-stage breakpoint tag.
// Assumes: halted comes from the state controller; sources are ignored
// while halted or while dbg_en is low.
module dbg_src_merge
    import dbg_entry_pkg::*;
#(
    parameter int CTRL_W   = 4,
    parameter int HALT_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halted,
    input  logic              dbg_en,
    input  logic              ext_req,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              dmem_req,
    input  logic              dwpt,
    input  slot_t             ex_slot,
    output logic              req_core,
    output cause_t            hits,
    output logic              entry
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              dmem_q;
    cause_t            raw;

    // Control register: plain load on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_wdata;
        end
    end

    // Remember a data request so the watchpoint flag is taken a cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dmem_q <= 1'b0;
        end else begin
            dmem_q <= dmem_req & ~halted;
        end
    end

    assign req_core = ext_req | ctrl_q[HALT_BIT];

    // Raw source vector in cause-bit order.
    always_comb begin
        raw             = '0;
        raw[CAUSE_EXT]  = ext_req;
        raw[CAUSE_CTRL] = ctrl_q[HALT_BIT];
        raw[CAUSE_BKPT] = ex_slot.vld & ex_slot.bkpt;
        raw[CAUSE_WPT]  = dmem_q & dwpt;
    end

    assign hits  = (dbg_en && !halted) ? raw : '0;
    assign entry = |hits;
endmodule

// File: rtl/dbg_state_ctl.sv
// Debug state flag, sticky cause record and executed pulse.
// Assumes: entry is only raised outside debug state; restart is honoured
// only while halted.
module dbg_state_ctl
    import dbg_entry_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   dbg_en,
    input  logic   entry,
    input  cause_t hits,
    input  logic   restart,
    input  slot_t  ex_slot,
    input  logic   cond_pass,
    output logic   halted,
    output cause_t cause,
    output logic   instr_exec
);
    logic leave;
    logic bk_block;

    assign leave    = halted & restart;
    assign bk_block = dbg_en & ex_slot.bkpt;

    // Debug state flag: set on entry, cleared by restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted <= 1'b0;
        end else if (leave) begin
            halted <= 1'b0;
        end else if (entry) begin
            halted <= 1'b1;
        end
    end

    // Cause record: accumulate at entry, wipe on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause <= '0;
        end else if (leave) begin
            cause <= '0;
        end else if (entry) begin
            cause <= cause | hits;
        end
    end

    // Executed pulse for the instruction that just left execute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_exec <= 1'b0;
        end else begin
            instr_exec <= ~halted & ex_slot.vld & cond_pass & ~bk_block;
        end
    end
endmodule

// File: rtl/dbg_entry_ctrl.sv
// Top of the debug-entry controller: pipeline token model, source merge
// and state control.
// Assumes: single clock, synchronous active-low reset.
module dbg_entry_ctrl
    import dbg_entry_pkg::*;
#(
    parameter int CTRL_W   = 4,
    parameter int HALT_BIT = 1,
    parameter int DEPTH    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_en,
    input  logic              ext_req,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              fetch_req,
    input  logic              ibkpt,
    input  logic              flush,
    input  logic              cond_pass,
    input  logic              dmem_req,
    input  logic              dwpt,
    input  logic              restart,
    output logic              dbg_req_core,
    output logic              dbg_ack,
    output logic              instr_exec,
    output logic [CAUSE_W-1:0] dbg_cause
);
    slot_t  ex_slot;
    cause_t hits;
    cause_t cause;
    logic   entry;
    logic   halted;

    dbg_pipe_model #(.DEPTH(DEPTH)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (halted),
        .drain_ex  (entry),
        .fetch_req (fetch_req),
        .flush     (flush),
        .ibkpt     (ibkpt),
        .ex_slot   (ex_slot)
    );

    dbg_src_merge #(.CTRL_W(CTRL_W), .HALT_BIT(HALT_BIT)) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .halted     (halted),
        .dbg_en     (dbg_en),
        .ext_req    (ext_req),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .dmem_req   (dmem_req),
        .dwpt       (dwpt),
        .ex_slot    (ex_slot),
        .req_core   (dbg_req_core),
        .hits       (hits),
        .entry      (entry)
    );

    dbg_state_ctl u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .dbg_en     (dbg_en),
        .entry      (entry),
        .hits       (hits),
        .restart    (restart),
        .ex_slot    (ex_slot),
        .cond_pass  (cond_pass),
        .halted     (halted),
        .cause      (cause),
        .instr_exec (instr_exec)
    );

    assign dbg_ack   = halted;
    assign dbg_cause = cause;
endmodule

// File: rtl/dbg_entry_chk.sv
// Property checker for dbg_entry_ctrl, attached by bind.
// Assumes: reset is held low across at least one rising edge.
module dbg_entry_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dbg_en,
    input logic       ext_req,
    input logic       dmem_req,
    input logic       dwpt,
    input logic       cond_pass,
    input logic       restart,
    input logic       dbg_req_core,
    input logic       dbg_ack,
    input logic       instr_exec,
    input logic [3:0] dbg_cause
);
    logic past_ok;

    // Marks that one full cycle has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r1_ext_merges: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> dbg_req_core);

    a_r2_ext_enters: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_en && ext_req && !dbg_ack |=> dbg_ack);

    a_r5_wpt_enters: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && dbg_en && dwpt && $past(dmem_req) && !$past(dbg_ack) && !dbg_ack
        |=> dbg_ack);

    a_r6_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_ack && !restart |=> dbg_ack);

    a_r6_no_exec_halted: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_ack |=> !instr_exec);

    a_r7_disabled_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_en && !dbg_ack |=> !dbg_ack);

    a_r8_exec_needs_cond: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && instr_exec |-> $past(cond_pass) && !$past(dbg_ack));

    a_r9_restart_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_ack && restart |=> !dbg_ack && dbg_cause == 4'b0000);

    a_r10_cause_tracks_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_cause != 4'b0000) == dbg_ack);
endmodule

bind dbg_entry_ctrl dbg_entry_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dbg_en       (dbg_en),
    .ext_req      (ext_req),
    .dmem_req     (dmem_req),
    .dwpt         (dwpt),
    .cond_pass    (cond_pass),
    .restart      (restart),
    .dbg_req_core (dbg_req_core),
    .dbg_ack      (dbg_ack),
    .instr_exec   (instr_exec),
    .dbg_cause    (dbg_cause)
);

// File: tb/dbg_entry_ctrl_bench.sv
module dbg_entry_ctrl_bench;
    localparam int CTRL_W = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n, dbg_en, ext_req, ctrl_we, fetch_req, ibkpt, flush;
    logic              cond_pass, dmem_req, dwpt, restart;
    logic [CTRL_W-1:0] ctrl_wdata;
    logic              dbg_req_core, dbg_ack, instr_exec;
    logic [3:0]        dbg_cause;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    dbg_entry_ctrl u_dbg_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .ext_req(ext_req),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .fetch_req(fetch_req),
        .ibkpt(ibkpt), .flush(flush), .cond_pass(cond_pass),
        .dmem_req(dmem_req), .dwpt(dwpt), .restart(restart),
        .dbg_req_core(dbg_req_core), .dbg_ack(dbg_ack),
        .instr_exec(instr_exec), .dbg_cause(dbg_cause)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        ext_req = 0; ctrl_we = 0; ctrl_wdata = '0; fetch_req = 0; ibkpt = 0;
        flush = 0; cond_pass = 0; dmem_req = 0; dwpt = 0; restart = 0;
    endtask

    task automatic leave_debug(input string tag);
        restart = 1; step(); restart = 0;
        check({tag, " ack after restart"}, dbg_ack, 0);
        check({tag, " cause after restart"}, dbg_cause, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        quiet(); dbg_en = 0; rst_n = 0;
        repeat (3) step();
        check("R11 ack in reset", dbg_ack, 0);
        check("R11 exec in reset", instr_exec, 0);
        check("R11 cause in reset", dbg_cause, 0);
        check("R11 merged req in reset", dbg_req_core, 0);
        rst_n = 1; step();
        check("R11 ack after reset", dbg_ack, 0);

        // R1 sweep of control values and external input, enable low (R7)
        for (int v = 0; v < 16; v++) begin
            for (int e = 0; e < 2; e++) begin
                ctrl_we = 1; ctrl_wdata = v[3:0]; ext_req = e[0];
                step(); ctrl_we = 0;
                check("R1 merged request", dbg_req_core, e[0] | v[1]);
                check("R7 no entry while disabled", dbg_ack, 0);
            end
        end
        ctrl_we = 1; ctrl_wdata = '0; ext_req = 0; step(); quiet();

        // R3/R4/R7/R8 sweep: enable, tag, condition, flush position
        for (int en = 0; en < 2; en++)
        for (int bk = 0; bk < 2; bk++)
        for (int cd = 0; cd < 2; cd++)
        for (int fl = 0; fl < 4; fl++) begin
            bit kill, halt, exe;
            string tg;
            kill = (fl == 1) || (fl == 2);
            halt = !kill && bk && en;
            exe  = !kill && !halt && cd;
            tg   = kill ? "R4 flushed" : (en ? "R3 breakpoint" : "R7 disabled tag");
            dbg_en = en[0];
            fetch_req = 1; step(); fetch_req = 0;
            for (int k = 1; k <= 4; k++) begin
                ibkpt     = (k == 1) ? bk[0] : 1'b0;
                flush     = (fl == k);
                cond_pass = (k == 3) ? cd[0] : 1'b0;
                step();
                quiet();
                check({tg, " ack"}, dbg_ack, halt && k >= 3);
                check("R8 exec pulse", instr_exec, exe && k == 3);
            end
            if (halt) begin
                check("R10 breakpoint cause", dbg_cause, 4'b0100);
                leave_debug("R9");
            end
            step();
        end
        dbg_en = 1;

        // R2: external request at the boundary, execute instruction completes
        fetch_req = 1; step(); fetch_req = 0;
        step(); step();
        cond_pass = 1; ext_req = 1; step(); quiet();
        check("R2 ext entry ack", dbg_ack, 1);
        check("R2 executing instr completes", instr_exec, 1);
        check("R10 ext cause", dbg_cause, 4'b0001);
        leave_debug("R9");
        ext_req = 1; step(); quiet();
        check("R2 ext entry empty pipe", dbg_ack, 1);
        leave_debug("R9");

        // R6: frozen pipeline while halted
        fetch_req = 1; step(); fetch_req = 0;
        ext_req = 1; step(); ext_req = 0;
        check("R6 entry", dbg_ack, 1);
        for (int m = 0; m < 4; m++) begin
            cond_pass = 1; fetch_req = 1; dmem_req = 1; dwpt = 1; flush = (m == 2);
            step();
            check("R6 ack held", dbg_ack, 1);
            check("R6 no exec while halted", instr_exec, 0);
            check("R6 cause frozen", dbg_cause, 4'b0001);
        end
        quiet();
        leave_debug("R9");
        for (int m = 1; m <= 4; m++) begin
            cond_pass = 1; step();
            check("R6 resumed token timing", instr_exec, m == 3);
            check("R6 no spurious entry", dbg_ack, 0);
        end
        quiet();

        // R9: control bit re-entry
        ctrl_we = 1; ctrl_wdata = 4'b0010; step(); ctrl_we = 0;
        check("R2 ctrl not yet", dbg_ack, 0);
        step();
        check("R2 ctrl entry", dbg_ack, 1);
        check("R10 ctrl cause", dbg_cause, 4'b0010);
        leave_debug("R9");
        step();
        check("R9 re-entry with bit set", dbg_ack, 1);
        ctrl_we = 1; ctrl_wdata = 4'b0000; step(); ctrl_we = 0;
        leave_debug("R9");
        step(); step();
        check("R9 stays out once cleared", dbg_ack, 0);

        // R5 sweep: enable, data request, watchpoint flag
        for (int en = 0; en < 2; en++)
        for (int dm = 0; dm < 2; dm++)
        for (int dw = 0; dw < 2; dw++) begin
            bit hit;
            hit = en && dm && dw;
            dbg_en = en[0];
            dmem_req = dm[0]; step(); dmem_req = 0;
            check("R5 no entry on request cycle", dbg_ack, 0);
            dwpt = dw[0]; step(); dwpt = 0;
            check("R5 watchpoint ack", dbg_ack, hit);
            check("R10 watchpoint cause", dbg_cause, hit ? 4'b1000 : 4'b0000);
            if (hit) leave_debug("R9");
            step();
        end
        dbg_en = 1;
        dmem_req = 1; dwpt = 1; step(); quiet();
        check("R5 same-cycle flag ignored", dbg_ack, 0);
        step();
        check("R5 same-cycle flag ignored later", dbg_ack, 0);

        // R10: all sources in one cycle
        fetch_req = 1; step(); fetch_req = 0;
        ibkpt = 1; step(); ibkpt = 0;
        ctrl_we = 1; ctrl_wdata = 4'b0010; dmem_req = 1; step(); quiet();
        check("R10 nothing before joint cycle", dbg_ack, 0);
        ext_req = 1; dwpt = 1; cond_pass = 1; step(); quiet();
        check("R10 joint entry", dbg_ack, 1);
        check("R10 joint cause", dbg_cause, 4'b1111);
        check("R3 tagged instr suppressed", instr_exec, 0);
        ctrl_we = 1; ctrl_wdata = '0; step(); quiet();
        check("R10 cause sticky", dbg_cause, 4'b1111);
        leave_debug("R9");
        step();
        check("R10 single entry only", dbg_ack, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule